// File: doc/BRIEF.md
# Baud and Sampling Clock Enable Generator

This block turns a selectable timing source into the bit-period enable for a serial transmitter and receiver. It also produces the sampling enable that the receiver uses inside each bit. There are three usable sources: every cycle of the peripheral clock, one cycle in eight from a free-running prescaler, or the rising edges of an external serial clock pin. The external pin is brought into the peripheral clock domain, so the whole block runs from one clock and produces only one-cycle enables.

The chosen source events pass through a 16-bit programmable divisor. A divisor of zero stops the bit enable completely. A divisor of one passes every source event straight through. A new divisor is picked up only at the end of a period, so the period in progress always completes at its old length. The sampling enable is either the bit enable divided by an oversampling ratio (16 or 8), or, in synchronous mode, the bit enable itself. When synchronous mode uses the external clock, the sampling enable follows the synchronised external edges directly.

Top module: `baud_clkgen`

## Requirements
- R1: With `src_sel` = 0 every peripheral clock cycle is a source event, so a divisor of 1 gives `baud_en` high on every cycle after reset release.
- R2: With `src_sel` = 1 a source event occurs once every 8 cycles, from a 3-bit prescaler cleared by reset; the first event is at the 8th rising clock edge after release.
- R3: With `src_sel` = 3 each rising edge of `ext_clk` is one source event. The pin passes through two synchronising flops and an edge detector, so an edge set up before clock edge k yields the event at edge k+2.
- R4: `src_sel` = 2 is reserved and produces no source event, so `baud_en` stays low.
- R5: A divisor of 0 keeps `baud_en` low for as long as it stays 0.
- R6: A divisor N of 2 or more gives one `baud_en` pulse for every N source events. A divisor of 1 gives a pulse for every source event. Each pulse lasts one cycle, on the edge after the completing event.
- R7: A divisor change takes effect only once the running period has completed; the period in progress keeps its old length.
- R8: With `sync_mode` = 0, `samp_en` pulses once per 16 `baud_en` pulses when `over_sel` = 0, and once per 8 when `over_sel` = 1. The pulse comes one cycle after the completing `baud_en`.
- R9: With `sync_mode` = 1, `samp_en` repeats `baud_en` one cycle later. When `src_sel` = 3 it instead pulses on each synchronised external rising edge, whatever the divisor is.
- R10: A synchronous active-high `rst` clears all counters and holds both outputs low. After release, the first `baud_en` comes exactly one full divisor period of source events later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Source select: 0 every cycle, 1 prescaled by 8, 2 reserved, 3 external pin |
| divisor | input | 16 | Bit-period divisor in source events (0 silences, 1 bypasses) |
| over_sel | input | 1 | Oversampling ratio: 0 selects 16, 1 selects 8 |
| sync_mode | input | 1 | 1 skips the oversampling divider |
| ext_clk | input | 1 | Asynchronous external serial clock |
| baud_en | output | 1 | One-cycle bit-period enable |
| samp_en | output | 1 | One-cycle sampling enable |

## Verification
A corrupted divisor count shows up as a wrong gap between `baud_en` pulses, either within one period or, when the fault is in reload, one period after a divisor write. A wrong oversampling count moves the first `samp_en` pulse by whole bit periods, so it appears within 8 or 16 bit periods. A fault in the synchroniser or the edge detector shifts the external-source latency by whole cycles, or doubles the pulses, and this is visible from the first external edge.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [1:0] {
    SRC_PCLK = 2'd0,
    SRC_PRE  = 2'd1,
    SRC_RSVD = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;
endpackage

// File: rtl/bcg_src_select.sv
module bcg_src_select
  import bcg_pkg::*;
#(
  parameter int PRE_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  src_e sel_i,
  input  logic ext_clk_i,
  output logic src_en_o,
  output logic ext_edge_o
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0]       pre_cnt;
  logic                   pre_tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev;

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else if (pre_cnt == PRE_LAST) pre_cnt <= '0;
    else pre_cnt <= pre_cnt + 1'b1;
  end
  assign pre_tick = (pre_cnt == PRE_LAST);

  // synchroniser chain, one flop per stage
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else sync_q[0] <= ext_clk_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ext_prev <= 1'b0;
    else ext_prev <= sync_q[SYNC_STAGES-1];
  end
  assign ext_edge_o = sync_q[SYNC_STAGES-1] & ~ext_prev;

  always_comb begin
    unique case (sel_i)
      SRC_PCLK: src_en_o = 1'b1;
      SRC_PRE:  src_en_o = pre_tick;
      SRC_EXT:  src_en_o = ext_edge_o;
      default:  src_en_o = 1'b0;
    endcase
  end

  // R3
  ext_edge_single_chk: assert property (@(posedge clk) disable iff (rst)
    ext_edge_o |=> !ext_edge_o);
  // R2
  pre_tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    pre_tick |=> !pre_tick);
  // R4
  rsvd_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_i == SRC_RSVD) |-> !src_en_o);
endmodule

// File: rtl/bcg_divider.sv
module bcg_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_en_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             baud_en_o
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      baud_en_o <= 1'b0;
    end else begin
      baud_en_o <= 1'b0;
      if (src_en_i) begin
        if (cnt == '0) begin
          // period boundary: the divisor is sampled only here
          if (divisor_i == DIV_W'(1)) baud_en_o <= 1'b1;
          else if (divisor_i != '0) cnt <= divisor_i - 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
          if (cnt == DIV_W'(1)) baud_en_o <= 1'b1;
        end
      end
    end
  end

  // R6
  baud_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
    baud_en_o |-> $past(src_en_i));
  // R5
  zero_div_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (src_en_i && cnt == '0 && divisor_i == '0) |=> !baud_en_o);
  // R7
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt > DIV_W'(1) && src_en_i) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/bcg_sampler.sv
module bcg_sampler #(
  parameter int OVS_SLOW = 16,
  parameter int OVS_FAST = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic baud_en_i,
  input  logic ext_edge_i,
  input  logic use_ext_i,
  input  logic over_i,
  input  logic sync_i,
  output logic samp_en_o
);
  localparam int OVS_MAX = (OVS_SLOW > OVS_FAST) ? OVS_SLOW : OVS_FAST;
  localparam int OVS_W   = $clog2(OVS_MAX);
  localparam logic [OVS_W-1:0] LAST_SLOW = OVS_W'(OVS_SLOW - 1);
  localparam logic [OVS_W-1:0] LAST_FAST = OVS_W'(OVS_FAST - 1);

  logic [OVS_W-1:0] ocnt;
  logic [OVS_W-1:0] last;

  assign last = over_i ? LAST_FAST : LAST_SLOW;

  always_ff @(posedge clk) begin
    if (rst) begin
      ocnt      <= '0;
      samp_en_o <= 1'b0;
    end else if (sync_i) begin
      ocnt      <= '0;
      samp_en_o <= use_ext_i ? ext_edge_i : baud_en_i;
    end else begin
      samp_en_o <= 1'b0;
      if (baud_en_i) begin
        if (ocnt >= last) begin
          ocnt      <= '0;
          samp_en_o <= 1'b1;
        end else begin
          ocnt <= ocnt + 1'b1;
        end
      end
    end
  end

  // R8
  async_samp_from_baud_chk: assert property (@(posedge clk) disable iff (rst)
    (samp_en_o && $past(!sync_i)) |-> $past(baud_en_i));
  // R8
  async_samp_spaced_chk: assert property (@(posedge clk) disable iff (rst)
    (samp_en_o && !sync_i) |=> !samp_en_o);
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen
  import bcg_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int PRE_DIV     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OVS_SLOW    = 16,
  parameter int OVS_FAST    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] divisor,
  input  logic             over_sel,
  input  logic             sync_mode,
  input  logic             ext_clk,
  output logic             baud_en,
  output logic             samp_en
);
  src_e sel;
  logic src_en;
  logic ext_edge;

  assign sel = src_e'(src_sel);

  bcg_src_select #(.PRE_DIV(PRE_DIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .sel_i(sel), .ext_clk_i(ext_clk),
    .src_en_o(src_en), .ext_edge_o(ext_edge)
  );

  bcg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .src_en_i(src_en), .divisor_i(divisor),
    .baud_en_o(baud_en)
  );

  bcg_sampler #(.OVS_SLOW(OVS_SLOW), .OVS_FAST(OVS_FAST)) u_samp (
    .clk(clk), .rst(rst), .baud_en_i(baud_en), .ext_edge_i(ext_edge),
    .use_ext_i(sel == SRC_EXT), .over_i(over_sel), .sync_i(sync_mode),
    .samp_en_o(samp_en)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!baud_en && !samp_en));
endmodule

// File: tb/sim_baud_clkgen.sv
module sim_baud_clkgen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  src_sel = 2'd0;
  logic [15:0] divisor = 16'd1;
  logic        over_sel = 1'b0;
  logic        sync_mode = 1'b0;
  logic        ext_clk = 1'b0;
  logic        baud_en, samp_en;

  int total = 0, bad = 0;
  int bcnt = 0, scnt = 0, b_seen = 0, rel_cnt = 0;
  int ext_half = 4;
  bit ext_run = 1'b0, done = 1'b0;
  int    bq[$];  string btag[$];
  int    sq[$];  string stag[$];

  always #10 clk = ~clk;

  baud_clkgen u0 (
    .clk(clk), .rst(rst), .src_sel(src_sel), .divisor(divisor),
    .over_sel(over_sel), .sync_mode(sync_mode), .ext_clk(ext_clk),
    .baud_en(baud_en), .samp_en(samp_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_b(input int n, input int gap, input string req);
    for (int i = 0; i < n; i++) begin bq.push_back(gap); btag.push_back(req); end
  endtask

  task automatic push_s(input int n, input int gap, input string req);
    for (int i = 0; i < n; i++) begin sq.push_back(gap); stag.push_back(req); end
  endtask

  task automatic start(input logic [1:0] s, input int d, input bit ov, input bit sy, input bit ex);
    @(negedge clk);
    rst = 1'b1; ext_run = 1'b0;
    src_sel = s; divisor = 16'(d); over_sel = ov; sync_mode = sy;
    repeat (2) @(negedge clk);
    check(!baud_en && !samp_en, "R10 outputs low in reset", {baud_en, samp_en}, 0);
    ext_run = ex;
    rst = 1'b0;
  endtask

  task automatic drain();
    while (bq.size() != 0 || sq.size() != 0) @(negedge clk);
  endtask

  // monitor: measures gaps since release or previous pulse, pops expected gaps
  initial forever begin
    @(posedge clk); #2;
    if (rst) begin
      bcnt = 0; scnt = 0; b_seen = 0; rel_cnt = 0;
    end else begin
      rel_cnt++; bcnt++; scnt++;
      if (baud_en) begin
        b_seen++;
        if (bq.size() != 0) begin
          int e; string t;
          e = bq.pop_front(); t = btag.pop_front();
          check(bcnt == e, t, bcnt, e);
        end
        bcnt = 0;
      end
      if (samp_en) begin
        if (sq.size() != 0) begin
          int e; string t;
          e = sq.pop_front(); t = stag.pop_front();
          check(scnt == e, t, scnt, e);
        end
        scnt = 0;
      end
    end
  end

  // external clock source: low for ext_half cycles, high for ext_half cycles
  initial forever begin
    @(negedge clk);
    ext_clk = ext_run && (((rel_cnt / ext_half) % 2) == 1);
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 R6 R8: every cycle source, divisor 1, ratio 8
    start(2'd0, 1, 1'b1, 1'b0, 1'b0);
    push_b(20, 1, "R1 R6 bypass gap");
    push_s(1, 9, "R8 first sample ratio 8");
    push_s(2, 8, "R8 sample ratio 8");
    drain();

    // R6 R7 R10: divisor 5 changed to 3 mid-period
    start(2'd0, 5, 1'b0, 1'b0, 1'b0);
    push_b(3, 5, "R7 R10 old period kept");
    push_b(2, 3, "R7 new divisor applied");
    while (b_seen < 2) @(negedge clk);
    @(negedge clk);
    divisor = 16'd3;
    drain();

    // R2: prescaled source, divisor 2
    start(2'd1, 2, 1'b0, 1'b0, 1'b0);
    push_b(4, 16, "R2 prescaled gap");
    drain();

    // R3: external source, divisor 1
    ext_half = 4;
    start(2'd3, 1, 1'b0, 1'b0, 1'b1);
    push_b(1, 7, "R3 first external latency");
    push_b(3, 8, "R3 external period");
    drain();

    // R8: ratio 16 with divisor 2
    start(2'd0, 2, 1'b0, 1'b0, 1'b0);
    push_s(1, 33, "R8 first sample ratio 16");
    push_s(1, 32, "R8 sample ratio 16");
    drain();

    // R9: synchronous mode repeats baud_en
    start(2'd0, 3, 1'b0, 1'b1, 1'b0);
    push_b(3, 3, "R6 divisor 3 gap");
    push_s(1, 4, "R9 sync first sample");
    push_s(2, 3, "R9 sync sample");
    drain();

    // R9 R5: synchronous external mode with divisor 0
    start(2'd3, 0, 1'b0, 1'b1, 1'b1);
    push_s(1, 7, "R9 sync external first");
    push_s(2, 8, "R9 sync external period");
    drain();
    check(b_seen == 0, "R5 zero divisor in sync external", b_seen, 0);

    // R4: reserved source
    start(2'd2, 1, 1'b0, 1'b0, 1'b0);
    repeat (120) @(negedge clk);
    check(b_seen == 0, "R4 reserved source silent", b_seen, 0);

    // R5: divisor 0 on every-cycle source
    start(2'd0, 0, 1'b0, 1'b0, 1'b0);
    repeat (120) @(negedge clk);
    check(b_seen == 0, "R5 zero divisor silent", b_seen, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule